// File: doc/BRIEF.md
# TDD Radio State Sequencer

This block steers a half-duplex (time-division) radio between its receive, transmit and idle-ready states from two hardware pins. The baseband controller drives an enable pin and a direction pin. Each rising edge on the enable pin moves the machine one step. From the ready state it enters receive or transmit, depending on the level of the direction pin. From receive or transmit it returns to the ready state.

While the machine waits in the ready state, the two synthesizer enables track the direction pin. A change to "transmit" shuts the receive synthesizer down and brings up the transmit synthesizer. A change to "receive" does the reverse. Each switch also raises a one-cycle calibration request to the synthesizer that has just been turned on. Because of this, the controller can flip the direction pin early in the ready interval, and the synthesizer gets the time until the next enable edge to calibrate and lock.

Both pins are asynchronous to the block clock. They pass through a multi-stage synchronizer, and edges are found on the synchronized copies.

Top module: `tdd_seq_top`

## Requirements
- R1: After reset the state output reads ready (code 2'b00), the receive synthesizer enable is 1, the transmit enable is 0, and neither calibration request is active.
- R2: A rising edge on the enable pin in the ready state, with the direction pin high, moves the state to transmit (code 2'b10).
- R3: A rising edge on the enable pin in the ready state, with the direction pin low, moves the state to receive (code 2'b01).
- R4: A rising edge on the enable pin in receive or transmit returns the state to ready (code 2'b00).
- R5: In the ready state, a low-to-high change of the direction pin clears the receive enable, sets the transmit enable, and raises exactly one transmit calibration request.
- R6: In the ready state, a high-to-low change of the direction pin clears the transmit enable, sets the receive enable, and raises exactly one receive calibration request.
- R7: In receive or transmit, a change of the direction pin leaves both synthesizer enables unchanged and raises no calibration request.
- R8: Each calibration request is high for exactly one clock cycle.
- R9: Exactly one of the two synthesizer enables is high at all times after reset.
- R10: With the default two synchronizer stages, a direction change made before clock edge k appears on the synthesizer enables after edge k+2, and not before it.
- R11: A falling edge on the enable pin has no effect, and holding the pin high gives only one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_pin | input | 1 | Asynchronous step pin; a rising edge advances the state |
| dir_pin | input | 1 | Asynchronous direction pin; high selects transmit, low selects receive |
| state_o | output | 2 | Current state: 00 ready, 01 receive, 10 transmit |
| rx_synth_en | output | 1 | Receive synthesizer power enable |
| tx_synth_en | output | 1 | Transmit synthesizer power enable |
| rx_cal_req | output | 1 | One-cycle receive calibration request |
| tx_cal_req | output | 1 | One-cycle transmit calibration request |

## Verification
The bench flips the direction pin while the machine sits in receive. A design that let the synthesizers follow the pin outside the ready state would swap the enables there and emit a stray calibration request. It also holds the enable pin high for several cycles and then releases it. A level-sensitive or both-edge design would step more than once and land in the wrong state. The bench counts calibration pulses across repeated direction toggles and samples the enables on each cycle of the synchronizer path. A stretched pulse, a missing pulse or a wrong number of stages would show up as a wrong count or a one-cycle shift.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;
   typedef enum logic [1:0] {
      ST_READY = 2'b00,
      ST_RX    = 2'b01,
      ST_TX    = 2'b10
   } tdd_state_e;
endpackage

// File: rtl/tdd_seq_sync.sv
module tdd_seq_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tdd_seq_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("tdd_seq_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[LAST];
endmodule

// File: rtl/tdd_seq_edge.sv
module tdd_seq_edge #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] chg
);
   logic [W-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign chg[b] = lvl[b] ^ lvl_q[b];
      end
   endgenerate
endmodule

// File: rtl/tdd_seq_fsm.sv
module tdd_seq_fsm
   import tdd_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       dir_lvl,
   output tdd_state_e state
);
   tdd_state_e nxt;

   always_comb begin
      nxt = state;
      if (step) begin
         unique case (state)
            ST_READY: nxt = dir_lvl ? ST_TX : ST_RX;
            ST_RX,
            ST_TX:    nxt = ST_READY;
            default:  nxt = ST_READY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_READY;
      else        state <= nxt;
   end

   assert_to_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && step && dir_lvl) |=> state == ST_TX);
   assert_to_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && step && !dir_lvl) |=> state == ST_RX);
   assert_back_to_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_READY && step) |=> state == ST_READY);
   assert_hold_without_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state));
   assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'b11);
endmodule

// File: rtl/tdd_seq_synth.sv
module tdd_seq_synth
   import tdd_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  tdd_state_e state,
   input  logic       dir_rise,
   input  logic       dir_fall,
   output logic       rx_en,
   output logic       tx_en,
   output logic       rx_cal,
   output logic       tx_cal
);
   logic in_ready;
   assign in_ready = (state == ST_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en  <= 1'b1;
         tx_en  <= 1'b0;
         rx_cal <= 1'b0;
         tx_cal <= 1'b0;
      end else begin
         rx_cal <= 1'b0;
         tx_cal <= 1'b0;
         if (in_ready && dir_rise) begin
            rx_en  <= 1'b0;
            tx_en  <= 1'b1;
            tx_cal <= 1'b1;
         end else if (in_ready && dir_fall) begin
            tx_en  <= 1'b0;
            rx_en  <= 1'b1;
            rx_cal <= 1'b1;
         end
      end
   end

   assert_rise_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && dir_rise) |=> (tx_en && !rx_en && tx_cal && !rx_cal));
   assert_fall_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && dir_fall) |=> (rx_en && !tx_en && rx_cal && !tx_cal));
   assert_frozen_outside_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> ($stable({rx_en, tx_en}) && !rx_cal && !tx_cal));
   assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cal |=> !tx_cal);
   assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cal |=> !rx_cal);
   assert_one_synth_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rx_en, tx_en}) == 1);
   assert_tx_on_has_cal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> tx_cal);
endmodule

// File: rtl/tdd_seq_top.sv
module tdd_seq_top
   import tdd_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable_pin,
   input  logic       dir_pin,
   output logic [1:0] state_o,
   output logic       rx_synth_en,
   output logic       tx_synth_en,
   output logic       rx_cal_req,
   output logic       tx_cal_req
);
   localparam int NPIN = 2;
   localparam int B_EN = 0;
   localparam int B_DIR = 1;

   logic [NPIN-1:0] pin_s;
   logic [NPIN-1:0] pin_chg;
   tdd_state_e      state;
   logic            step, dir_rise, dir_fall;

   tdd_seq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({dir_pin, enable_pin}), .q(pin_s));

   tdd_seq_edge #(.W(NPIN)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s), .chg(pin_chg));

   assign step     = pin_chg[B_EN]  &  pin_s[B_EN];
   assign dir_rise = pin_chg[B_DIR] &  pin_s[B_DIR];
   assign dir_fall = pin_chg[B_DIR] & ~pin_s[B_DIR];

   tdd_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .step(step), .dir_lvl(pin_s[B_DIR]), .state(state));

   tdd_seq_synth u_synth (
      .clk(clk), .rst_n(rst_n), .state(state), .dir_rise(dir_rise), .dir_fall(dir_fall),
      .rx_en(rx_synth_en), .tx_en(tx_synth_en), .rx_cal(rx_cal_req), .tx_cal(tx_cal_req));

   assign state_o = state;
endmodule

// File: tb/sim_tdd_seq_top.sv
module sim_tdd_seq_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable_pin = 1'b0;
   logic dir_pin = 1'b0;
   logic [1:0] state_o;
   logic rx_synth_en, tx_synth_en, rx_cal_req, tx_cal_req;

   int total = 0;
   int bad = 0;
   int rx_pulses = 0;
   int tx_pulses = 0;
   int onehot_viol = 0;
   int long_pulse = 0;
   logic prev_rx_cal = 1'b0;
   logic prev_tx_cal = 1'b0;

   always #5 clk = ~clk;

   tdd_seq_top u0 (
      .clk(clk), .rst_n(rst_n), .enable_pin(enable_pin), .dir_pin(dir_pin),
      .state_o(state_o), .rx_synth_en(rx_synth_en), .tx_synth_en(tx_synth_en),
      .rx_cal_req(rx_cal_req), .tx_cal_req(tx_cal_req));

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_cal_req) rx_pulses++;
         if (tx_cal_req) tx_pulses++;
         if ((rx_cal_req && prev_rx_cal) || (tx_cal_req && prev_tx_cal)) long_pulse++;
         if ((rx_synth_en + tx_synth_en) != 1) onehot_viol++;
         prev_rx_cal = rx_cal_req;
         prev_tx_cal = tx_cal_req;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step_pulse();
      enable_pin = 1'b1;
      tick(6);
      enable_pin = 1'b0;
      tick(6);
   endtask

   task automatic clr_counts();
      rx_pulses = 0;
      tx_pulses = 0;
   endtask

   task automatic t_reset();
      chk(state_o == 2'b00, "R1 state", {30'd0, state_o}, 32'h0);
      chk(rx_synth_en && !tx_synth_en, "R1 enables",
          {30'd0, rx_synth_en, tx_synth_en}, 32'h2);
      chk(!rx_cal_req && !tx_cal_req, "R1 cal", {30'd0, rx_cal_req, tx_cal_req}, 32'h0);
   endtask

   task automatic t_latency();
      clr_counts();
      dir_pin = 1'b1;
      tick(2);
      chk(!tx_synth_en && rx_synth_en, "R10 early", {30'd0, rx_synth_en, tx_synth_en}, 32'h2);
      tick(1);
      chk(tx_synth_en && !rx_synth_en, "R10/R5 switch", {30'd0, rx_synth_en, tx_synth_en}, 32'h1);
      chk(tx_cal_req == 1'b1, "R5 tx cal", {31'd0, tx_cal_req}, 32'h1);
      tick(1);
      chk(tx_cal_req == 1'b0, "R8 tx cal width", {31'd0, tx_cal_req}, 32'h0);
      tick(4);
      chk(tx_pulses == 1 && rx_pulses == 0, "R5 pulse count", tx_pulses, 32'h1);
   endtask

   task automatic t_enter_tx();
      enable_pin = 1'b1;
      tick(8);
      chk(state_o == 2'b10, "R2 enter tx", {30'd0, state_o}, 32'h2);
      chk(state_o == 2'b10, "R11 held high", {30'd0, state_o}, 32'h2);
      enable_pin = 1'b0;
      tick(8);
      chk(state_o == 2'b10, "R11 falling edge", {30'd0, state_o}, 32'h2);
   endtask

   task automatic t_exit();
      step_pulse();
      chk(state_o == 2'b00, "R4 back to ready", {30'd0, state_o}, 32'h0);
   endtask

   task automatic t_fall();
      clr_counts();
      dir_pin = 1'b0;
      tick(6);
      chk(rx_synth_en && !tx_synth_en, "R6 switch", {30'd0, rx_synth_en, tx_synth_en}, 32'h2);
      chk(rx_pulses == 1 && tx_pulses == 0, "R6 pulse count", rx_pulses, 32'h1);
   endtask

   task automatic t_enter_rx();
      step_pulse();
      chk(state_o == 2'b01, "R3 enter rx", {30'd0, state_o}, 32'h1);
   endtask

   task automatic t_ignore();
      clr_counts();
      dir_pin = 1'b1;
      tick(6);
      chk(rx_synth_en && !tx_synth_en, "R7 enables held", {30'd0, rx_synth_en, tx_synth_en}, 32'h2);
      chk(state_o == 2'b01, "R7 state held", {30'd0, state_o}, 32'h1);
      dir_pin = 1'b0;
      tick(6);
      chk(rx_pulses == 0 && tx_pulses == 0, "R7 no cal", rx_pulses + tx_pulses, 32'h0);
      step_pulse();
      chk(state_o == 2'b00, "R4 rx to ready", {30'd0, state_o}, 32'h0);
   endtask

   task automatic t_toggles();
      clr_counts();
      for (int i = 0; i < 4; i++) begin
         dir_pin = ~dir_pin;
         tick(5);
      end
      chk(tx_pulses == 2 && rx_pulses == 2, "R5/R6 toggle counts", tx_pulses * 16 + rx_pulses, 32'h22);
      chk(long_pulse == 0, "R8 no stretched pulse", long_pulse, 32'h0);
      chk(onehot_viol == 0, "R9 one synth on", onehot_viol, 32'h0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_latency();
      t_enter_tx();
      t_exit();
      t_fall();
      t_enter_rx();
      t_ignore();
      t_toggles();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule